// File: doc/BRIEF.md
# Power-of-Two Scaled Uniform Quantizer

This block is a streaming datapath that maps a 16-bit signed fixed-point sample onto a small integer grid. The grid has uniformly spaced levels whose step is a power of two. Because the step is a power of two, the divide by the scale is a rounded arithmetic shift and the multiply back is a plain shift. No multiplier and no divider are used. For each accepted sample the block returns the integer level (the code), the code rescaled to the input's fixed-point format (the dequantized value), and a flag that tells whether the level had to be clamped.

One shift exponent serves a whole tensor. It is loaded through a configuration strobe and stays in a register until the next load. The code range is set per sample by a signed/unsigned mode bit and a runtime bit-width. In signed mode the range is symmetric around zero and never uses the most negative two's-complement code. In unsigned mode the range starts at zero. The zero point is always zero, so no offset is added anywhere. Samples move through two register stages with no backpressure.

Top module: `pow2_quantizer`

## Requirements
- R1: The code equals clip(round(x / 2^e), qmin, qmax). Rounding is applied to the scaled value before it is clamped.
- R2: Rounding is to nearest, and an exact half moves away from zero. For example, with e = 1 the inputs 3 and -3 give codes 2 and -2.
- R3: A negative exponent e scales the input up by 2^-e. The input is shifted left by -e bits and no rounding takes place.
- R4: In signed mode (mode bit = 1) codes lie in [-(2^(bw-1)-1), 2^(bw-1)-1]. The code -2^(bw-1) never appears. The code is driven as an 8-bit two's-complement value.
- R5: In unsigned mode (mode bit = 0) codes lie in [0, 2^bw-1] and are zero-extended to 8 bits. Every negative input gives code 0.
- R6: The saturation flag is 1 exactly when clamping changed the rounded value. This includes a negative input in unsigned mode that did not round to zero.
- R7: The dequantized output is code × 2^e, sign-extended to 16 bits. For e < 0 the magnitude is truncated toward zero. The magnitude is limited to 32767, so the output is never -32768.
- R8: The exponent register changes only on a cycle with the load strobe. A sample accepted in the same cycle as a load still uses the previous exponent, and the loaded value applies from the next sample on.
- R9: Each sample's results appear exactly two clock cycles after it was accepted, with out_valid high. While out_valid is low, the code, the dequantized value and the flag are all zero.
- R10: While reset is high, and directly after it, out_valid, out_code, out_deq and out_sat are zero and the exponent register holds 0.
- R11: A bit-width request below 2 is treated as 2, and a request above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load strobe for the scale exponent |
| cfg_exp | input | 5 | Signed scale exponent e (-16..15) |
| in_valid | input | 1 | Sample valid |
| in_data | input | 16 | Signed input sample |
| in_signed | input | 1 | 1 = symmetric signed range, 0 = unsigned range |
| in_bw | input | 4 | Requested code bit-width |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_code | output | 8 | Quantized code |
| out_deq | output | 16 | Dequantized value, signed |
| out_sat | output | 1 | Clamp changed the rounded value |

## Verification
The functions that share a cycle are an exponent reload and a sample that is either entering the pipeline or already inside it. Samples arriving with cfg_load high must be scaled by the old exponent. Samples already in flight must keep their own exponent all the way to the rescale stage. The bench provokes this with a directed burst and with random loads that fall on back-to-back valid samples. Each result is judged against a bench model whose exponent copy updates only after the sample of that cycle has been modelled. The second overlap is clamping together with dequantized-value saturation. Large exponents push both limits in one sample, and the code, flag and value are each compared on their own.

// File: rtl/pow2q_pkg.sv
package pow2q_pkg;

    localparam int DATA_W    = 16;
    localparam int CODE_W    = 8;
    localparam int EXP_W     = 5;
    localparam int BW_W      = 4;
    localparam int BW_MIN    = 2;
    localparam int BW_MAX    = CODE_W;
    localparam int SHIFT_MAX = 2 ** (EXP_W - 1);
    localparam int MAG_W     = DATA_W + SHIFT_MAX;
    localparam int DEQ_W     = CODE_W + SHIFT_MAX;

    typedef logic signed [EXP_W-1:0] exp_t;

    // State between the scale/round stage and the clamp/rescale stage
    typedef struct packed {
        logic             valid;
        logic             neg;
        logic             sgn;
        logic [BW_W-1:0]  bw;
        exp_t             exp;
        logic [MAG_W-1:0] mag;
    } scaled_t;

    typedef struct packed {
        logic                     valid;
        logic [CODE_W-1:0]        code;
        logic signed [DATA_W-1:0] deq;
        logic                     sat;
    } quant_t;

    function automatic logic [BW_W-1:0] clamp_bw(input logic [BW_W-1:0] bw);
        if (int'(bw) < BW_MIN) return BW_W'(BW_MIN);
        if (int'(bw) > BW_MAX) return BW_W'(BW_MAX);
        return bw;
    endfunction

    // Largest code magnitude for a mode and an already clamped width
    function automatic logic [CODE_W-1:0] level_max(input logic sgn, input logic [BW_W-1:0] bw);
        logic [CODE_W:0] one_hot;
        one_hot = (CODE_W+1)'(1) << (sgn ? bw - BW_W'(1) : bw);
        return CODE_W'(one_hot - (CODE_W+1)'(1));
    endfunction

endpackage

// File: rtl/qnt_exp_reg.sv
module qnt_exp_reg
    import pow2q_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  exp_t exp_in,
    output exp_t exp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
        end else if (load) begin
            exp_q <= exp_in;
        end
    end

endmodule

// File: rtl/qnt_scale_round.sv
module qnt_scale_round
    import pow2q_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              sgn_i,
    input  logic [BW_W-1:0]   bw_i,
    input  exp_t              exp_i,
    output scaled_t           s1_o
);

    logic              neg;
    logic [DATA_W-1:0] mag_in;
    logic [MAG_W-1:0]  wide;
    logic [MAG_W-1:0]  gvec;
    logic [MAG_W-1:0]  mag_r;
    logic [EXP_W-2:0]  rsh;
    logic [EXP_W-1:0]  lsh;
    logic              guard;

    always_comb begin
        neg    = data_i[DATA_W-1];
        mag_in = neg ? (~data_i + DATA_W'(1)) : data_i;
        wide   = MAG_W'(mag_in);
        rsh    = exp_i[EXP_W-2:0];
        lsh    = ~exp_i + EXP_W'(1);
        gvec   = '0;
        guard  = 1'b0;
        if (!exp_i[EXP_W-1]) begin
            if (rsh != '0) begin
                gvec  = wide >> (rsh - (EXP_W-1)'(1));
                guard = gvec[0];
            end
            // magnitude rounding: guard bit set means fraction >= one half
            mag_r = (wide >> rsh) + MAG_W'(guard);
        end else begin
            mag_r = wide << lsh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_o <= '0;
        end else begin
            s1_o.valid <= valid_i;
            s1_o.neg   <= neg;
            s1_o.sgn   <= sgn_i;
            s1_o.bw    <= clamp_bw(bw_i);
            s1_o.exp   <= exp_i;
            s1_o.mag   <= mag_r;
        end
    end

endmodule

// File: rtl/qnt_clamp_rescale.sv
module qnt_clamp_rescale
    import pow2q_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  scaled_t s1_i,
    output quant_t  q_o
);

    localparam logic [DEQ_W-1:0] DEQ_LIM = DEQ_W'((1 << (DATA_W - 1)) - 1);

    logic [CODE_W-1:0] qmax;
    logic [CODE_W-1:0] cmag;
    logic              over;
    logic              sat;
    logic [CODE_W-1:0] code;
    logic [DEQ_W-1:0]  dwide;
    logic [DATA_W-1:0] dmag;
    logic [EXP_W-1:0]  lsh;
    logic              flip;

    always_comb begin
        qmax = level_max(s1_i.sgn, s1_i.bw);
        over = s1_i.mag > MAG_W'(qmax);
        flip = s1_i.neg && s1_i.sgn;
        if (s1_i.neg && !s1_i.sgn) begin
            cmag = '0;
            sat  = (s1_i.mag != '0);
        end else begin
            cmag = over ? qmax : s1_i.mag[CODE_W-1:0];
            sat  = over;
        end
        code = flip ? (~cmag + CODE_W'(1)) : cmag;

        lsh = ~s1_i.exp + EXP_W'(1);
        if (!s1_i.exp[EXP_W-1]) begin
            dwide = DEQ_W'(cmag) << s1_i.exp[EXP_W-2:0];
        end else begin
            dwide = DEQ_W'(cmag) >> lsh;
        end
        dmag = (dwide > DEQ_LIM) ? DATA_W'(DEQ_LIM) : dwide[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !s1_i.valid) begin
            q_o <= '0;
        end else begin
            q_o.valid <= 1'b1;
            q_o.code  <= code;
            q_o.deq   <= flip ? $signed(~dmag + DATA_W'(1)) : $signed(dmag);
            q_o.sat   <= sat;
        end
    end

endmodule

// File: rtl/pow2_quantizer.sv
module pow2_quantizer
    import pow2q_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_load,
    input  logic signed [EXP_W-1:0]  cfg_exp,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     in_signed,
    input  logic [BW_W-1:0]          in_bw,
    output logic                     out_valid,
    output logic [CODE_W-1:0]        out_code,
    output logic signed [DATA_W-1:0] out_deq,
    output logic                     out_sat
);

    exp_t    exp_q;
    scaled_t s1;
    quant_t  q;

    qnt_exp_reg u_exp (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .exp_in (cfg_exp),
        .exp_q  (exp_q)
    );

    qnt_scale_round u_s1 (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .data_i  (in_data),
        .sgn_i   (in_signed),
        .bw_i    (in_bw),
        .exp_i   (exp_q),
        .s1_o    (s1)
    );

    qnt_clamp_rescale u_s2 (
        .clk  (clk),
        .rst  (rst),
        .s1_i (s1),
        .q_o  (q)
    );

    assign out_valid = q.valid;
    assign out_code  = q.code;
    assign out_deq   = q.deq;
    assign out_sat   = q.sat;

endmodule

// File: rtl/pow2_quantizer_chk.sv
module pow2_quantizer_chk
    import pow2q_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_load,
    input logic signed [EXP_W-1:0]  cfg_exp,
    input logic                     in_valid,
    input logic                     in_signed,
    input logic [BW_W-1:0]          in_bw,
    input logic                     out_valid,
    input logic [CODE_W-1:0]        out_code,
    input logic signed [DATA_W-1:0] out_deq,
    input logic                     out_sat,
    input logic signed [EXP_W-1:0]  exp_q
);

    logic [1:0]        age;
    logic              sgn_d1, sgn_d2;
    logic [BW_W-1:0]   bw_d1, bw_d2;
    logic [CODE_W-1:0] qm_d2;
    int                code_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            age    <= '0;
            sgn_d1 <= 1'b0;
            sgn_d2 <= 1'b0;
            bw_d1  <= '0;
            bw_d2  <= '0;
        end else begin
            if (age != 2'd2) age <= age + 2'd1;
            sgn_d1 <= in_signed;
            sgn_d2 <= sgn_d1;
            bw_d1  <= in_bw;
            bw_d2  <= bw_d1;
        end
    end

    always_comb begin
        qm_d2  = level_max(sgn_d2, clamp_bw(bw_d2));
        code_s = int'($signed(out_code));
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_code == '0 && out_deq == '0 && !out_sat));

    // R4
    sym_range_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && out_valid && sgn_d2) |->
            (code_s <= int'(qm_d2) && code_s >= -int'(qm_d2)));

    // R5
    uns_range_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && out_valid && !sgn_d2) |-> (out_code <= qm_d2));

    // R6
    sat_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && out_sat) |->
            (out_code == '0 || code_s == int'(qm_d2) || code_s == -int'(qm_d2)
             || (!sgn_d2 && out_code == qm_d2)));

    // R7
    deq_floor_chk: assert property (@(posedge clk) disable iff (rst)
        out_deq != $signed({1'b1, {(DATA_W-1){1'b0}}}));

    // R8
    exp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(exp_q));

    // R8
    exp_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (exp_q == $past(cfg_exp)));

endmodule

bind pow2_quantizer pow2_quantizer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_exp   (cfg_exp),
    .in_valid  (in_valid),
    .in_signed (in_signed),
    .in_bw     (in_bw),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_deq   (out_deq),
    .out_sat   (out_sat),
    .exp_q     (exp_q)
);

// File: tb/pow2_quantizer_tb.sv
`timescale 1ns/1ps
module pow2_quantizer_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic signed [4:0] cfg_exp = '0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              in_signed = 1'b0;
    logic [3:0]        in_bw = 4'd8;
    logic              out_valid;
    logic [7:0]        out_code;
    logic signed [15:0] out_deq;
    logic              out_sat;

    int checks = 0;
    int errors = 0;
    int e_model = 0;
    bit done = 0;

    typedef struct {
        bit    v;
        int    code;
        int    deq;
        bit    sat;
        string tag;
    } exp_rec_t;

    exp_rec_t pa, pb;

    always #2 clk = ~clk;

    pow2_quantizer u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_exp   (cfg_exp),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_signed (in_signed),
        .in_bw     (in_bw),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_deq   (out_deq),
        .out_sat   (out_sat)
    );

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Expected result from the requirements: round half away from zero, then clamp
    function automatic exp_rec_t model(input int x, input int e, input bit sgn, input int bw_req);
        exp_rec_t r;
        int     b;
        longint mag, rnd, qmax, c, dm;
        b    = (bw_req < 2) ? 2 : ((bw_req > 8) ? 8 : bw_req);
        mag  = (x < 0) ? -longint'(x) : longint'(x);
        if (e > 0)       rnd = (mag + (longint'(1) << (e - 1))) >> e;
        else if (e == 0) rnd = mag;
        else             rnd = mag << (-e);
        qmax = sgn ? ((longint'(1) << (b - 1)) - 1) : ((longint'(1) << b) - 1);
        if (x < 0 && !sgn) begin
            c     = 0;
            r.sat = (rnd != 0);
        end else begin
            c     = (rnd > qmax) ? qmax : rnd;
            r.sat = (rnd > qmax);
        end
        dm = (e >= 0) ? (c << e) : (c >> (-e));
        if (dm > 32767) dm = 32767;
        if (x < 0 && sgn) begin
            c  = -c;
            dm = -dm;
        end
        r.v    = 1'b1;
        r.code = int'(c) & 8'hFF;
        r.deq  = int'(dm);
        r.tag  = "";
        return r;
    endfunction

    task automatic step(input bit v, input int x, input bit sgn, input int bw,
                        input bit ld, input int e_new, input string tag);
        exp_rec_t n;
        @(negedge clk);
        check("R9", out_valid, pb.v);
        if (pb.v) begin
            check(pb.tag, out_code, pb.code);
            check("R7", out_deq, pb.deq);
            check("R6", out_sat, pb.sat);
        end else begin
            check("R9", out_code, 0);
            check("R9", out_deq, 0);
            check("R9", out_sat, 0);
        end
        pb = pa;
        in_valid  = v;
        in_data   = 16'(x);
        in_signed = sgn;
        in_bw     = 4'(bw);
        cfg_load  = ld;
        cfg_exp   = 5'(e_new);
        if (v) begin
            n = model(x, e_model, sgn, bw);
            n.tag = tag;
        end else begin
            n = '{v: 1'b0, code: 0, deq: 0, sat: 1'b0, tag: ""};
        end
        pa = n;
        if (ld) e_model = e_new;
    endtask

    initial begin
        pa = '{v: 1'b0, code: 0, deq: 0, sat: 1'b0, tag: ""};
        pb = pa;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", out_valid, 0);
        check("R10", out_code, 0);
        check("R10", out_deq, 0);
        check("R10", out_sat, 0);
        rst = 1'b0;

        // R2: half away from zero with e = 1
        step(0, 0, 1, 8, 1, 1, "R2");
        step(1, 3, 1, 8, 0, 7, "R2");
        step(1, -3, 1, 8, 0, -5, "R2");
        step(1, 1, 1, 8, 0, 0, "R2");
        step(1, -1, 1, 8, 0, 0, "R2");
        // R4: symmetric limits, most negative code absent
        step(1, -32768, 1, 8, 0, 0, "R4");
        step(1, -1000, 1, 4, 0, 0, "R4");
        step(1, 1000, 1, 2, 0, 0, "R4");
        // R5: unsigned range and negative inputs
        step(1, 1000, 0, 8, 0, 0, "R5");
        step(1, -600, 0, 3, 0, 0, "R5");
        step(1, -1, 0, 3, 0, 0, "R5");
        // R11: width clamping
        step(1, 1000, 1, 0, 0, 0, "R11");
        step(1, -1000, 1, 15, 0, 0, "R11");
        step(1, 1000, 0, 12, 0, 0, "R11");
        // R3: negative exponent, shift up
        step(1, 5, 1, 8, 1, -3, "R1");
        step(1, 5, 1, 8, 0, 0, "R3");
        step(1, -7, 1, 8, 0, 0, "R3");
        step(1, 1, 0, 8, 0, 0, "R3");
        // R8: reload while samples are in flight and entering
        step(1, 100, 1, 8, 1, 4, "R8");
        step(1, 100, 1, 8, 1, -2, "R8");
        step(1, 100, 1, 8, 0, 9, "R8");
        step(1, 100, 1, 8, 0, 0, "R8");
        // R7: dequantized saturation with large exponent
        step(1, 32767, 1, 8, 1, 15, "R7");
        step(1, 32767, 1, 8, 0, 0, "R7");
        step(1, -32768, 1, 8, 0, 0, "R7");
        step(1, 32767, 0, 8, 0, 0, "R7");
        step(0, 0, 0, 8, 0, 0, "R9");

        // R1: random mix
        for (int i = 0; i < 1500; i++) begin
            bit ld;
            int e;
            ld = ($urandom_range(0, 9) == 0);
            e  = int'($urandom_range(0, 31)) - 16;
            step($urandom_range(0, 7) != 0, int'($signed(16'($urandom))),
                 1'($urandom), int'($urandom_range(0, 15)), ld, e, "R1");
        end
        step(0, 0, 0, 8, 0, 0, "R9");
        step(0, 0, 0, 8, 0, 0, "R9");
        step(0, 0, 0, 8, 0, 0, "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule